// File: doc/BRIEF.md
# Masked Completion Interrupt Aggregator

This block gathers per-descriptor completion pulses for three transfer categories (isochronous, interrupt and bulk) and decides when the processor should be interrupted. Each category keeps its own completion map and its own pair of masks. A per-bit "any" mask raises a request as soon as a selected descriptor completes. A group "all" mask raises a request once every selected descriptor in that category has completed. The masks of one category never look at another category's map.

A request sets a sticky, write-one-to-clear status bit for its category. The interrupt line follows the enabled status bits in level mode. In pulse mode it emits a fixed-length pulse that status writes cannot cut short. Bulk requests can be throttled: when interval mode is on, they are held and released only when a self-reloading interval timer expires. All state runs on an always-on clock, so requests still reach the line while the main system clock is stopped. Software reaches the block through a single-cycle synchronous register port. Reads are combinational on the address.

Register map (word addresses): 0/1/2 completion maps (iso/int/bulk, read, write 1 to clear a bit); 3/4/5 all-masks; 6/7/8 any-masks; 9 status (bit 0 iso, bit 1 int, bit 2 bulk, write 1 to clear); 10 line enable (same bit order); 11 control (bit 0 pulse mode, bit 1 bulk interval mode); 12 pulse length in cycles; 13 bulk interval in cycles. Unused addresses read 0.

Top module: `irq_aggr_top`

## Requirements
- R1: A completion pulse for descriptor n, sampled at clock edge t while any-mask bit n of that category is set, sets that category's status bit at edge t+1, whatever the all-mask holds.
- R2: When the all-mask is non-zero, a request is raised at the edge after the last of its selected completion bits becomes set, and not before all of them are set.
- R3: Masks and completion maps of one category never cause a request in another category.
- R4: A completion bit stays set after its request until software writes 1 to it. Writing 0 leaves it unchanged, and a pulse in the same cycle as its clear keeps it set.
- R5: A request always sets its status bit. The line is driven only if the matching enable bit (register 10) is set. A status bit stays set until a 1 is written to it, and a new request in the same cycle wins over the clear.
- R6: In level mode (control bit 0 = 0), the line is high exactly while some status bit and its enable bit are both set.
- R7: In pulse mode (control bit 0 = 1), an enabled request drives the line high for exactly the number of cycles held in register 12, starting after the edge that sets the status. Writes to status do not shorten the pulse.
- R8: In pulse mode, a further enabled request during a pulse restarts the full count from that request.
- R9: With control bit 1 set, a bulk request does not set bulk status until the interval timer expires. At expiry, every request held since the previous expiry sets bulk status once.
- R10: The interval timer reloads itself on expiry to a period of register 13 cycles. An expiry with no held bulk request raises nothing.
- R11: Clearing any selected completion bit re-arms the all-mask condition, so it can fire again once every selected bit is set again. Setting an already-set bit does not fire it again.
- R12: After reset all registers read 0 except pulse length (8) and interval (100), and the line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on clock for all block state |
| rst | input | 1 | Synchronous active-high reset |
| iso_evt_i | input | NDESC | Isochronous completion pulses, one bit per descriptor |
| intr_evt_i | input | NDESC | Interrupt-transfer completion pulses |
| bulk_evt_i | input | NDESC | Bulk completion pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | NDESC | Register write data |
| reg_rdata | output | NDESC | Register read data for reg_addr |
| irq_o | output | 1 | Processor interrupt line |

## Verification
The bench goes after several corner cases:
- An all-mask that is only partly met must stay silent. A design that fired on any selected bit would set status too early.
- Re-setting an already-set bit must not re-fire the all-mask condition. An edge detector keyed on events instead of the condition would raise duplicate requests, and one with no re-arm would never fire again.
- Pulse mode is counted cycle by cycle with a status clear in the middle and with a second request mid-pulse. A clear that cut the pulse, or a request that failed to restart the count, changes the count.
- Bulk throttling is checked before expiry, at expiry and across an empty interval. Leaking requests early, dropping the held request, or firing on every expiry would each show up in bulk status.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

    localparam int NCAT = 3;

    typedef enum logic [1:0] {
        CAT_ISO  = 2'd0,
        CAT_INTR = 2'd1,
        CAT_BULK = 2'd2
    } cat_e;

    typedef logic [3:0] addr_t;

    localparam addr_t A_DONE_BASE = 4'd0;
    localparam addr_t A_ALL_BASE  = 4'd3;
    localparam addr_t A_ANY_BASE  = 4'd6;
    localparam addr_t A_STAT      = 4'd9;
    localparam addr_t A_EN        = 4'd10;
    localparam addr_t A_CTRL      = 4'd11;
    localparam addr_t A_PLEN      = 4'd12;
    localparam addr_t A_IVAL      = 4'd13;

    typedef struct packed {
        logic ival_en;    // bit 1
        logic pulse_mode; // bit 0
    } ctrl_t;

    function automatic addr_t cat_addr(addr_t base, int c);
        return base + addr_t'(c);
    endfunction

endpackage

// File: rtl/irq_cat_eval.sv
module irq_cat_eval #(
    parameter int NDESC = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NDESC-1:0] evt_i,
    input  logic             done_we,
    input  logic             all_we,
    input  logic             any_we,
    input  logic [NDESC-1:0] wdata,
    output logic [NDESC-1:0] done_o,
    output logic [NDESC-1:0] all_o,
    output logic [NDESC-1:0] any_o,
    output logic             req_o
);
    logic [NDESC-1:0] done_q, all_q, any_q;
    logic             any_hit_q, all_seen_q, all_met;
    logic [NDESC-1:0] clr_bits;

    assign clr_bits = done_we ? wdata : '0;
    assign all_met  = (all_q != '0) && ((done_q & all_q) == all_q);
    assign req_o    = any_hit_q | (all_met & ~all_seen_q);
    assign done_o   = done_q;
    assign all_o    = all_q;
    assign any_o    = any_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q     <= '0;
            all_q      <= '0;
            any_q      <= '0;
            any_hit_q  <= 1'b0;
            all_seen_q <= 1'b0;
        end else begin
            done_q     <= (done_q & ~clr_bits) | evt_i;
            any_hit_q  <= |(evt_i & any_q);
            all_seen_q <= all_met;
            if (all_we) all_q <= wdata;
            if (any_we) any_q <= wdata;
        end
    end
endmodule

// File: rtl/irq_bulk_throttle.sv
module irq_bulk_throttle #(
    parameter int IVAL_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ival_en,
    input  logic [IVAL_W-1:0] ival_len,
    input  logic              req_i,
    output logic              set_o,
    output logic              expire_o
);
    logic [IVAL_W-1:0] tmr_q;
    logic              hold_q;

    assign expire_o = ival_en && (tmr_q == '0);
    assign set_o    = ival_en ? (expire_o && (hold_q || req_i)) : req_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            if (!ival_en || expire_o) tmr_q <= ival_len - 1'b1;
            else                      tmr_q <= tmr_q - 1'b1;
            if (!ival_en || expire_o) hold_q <= 1'b0;
            else                      hold_q <= hold_q | req_i;
        end
    end
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
    parameter int NCAT   = 3,
    parameter int PLEN_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pulse_mode,
    input  logic [NCAT-1:0]   en,
    input  logic [NCAT-1:0]   set_i,
    input  logic [NCAT-1:0]   clr_i,
    input  logic [PLEN_W-1:0] plen,
    output logic [NCAT-1:0]   stat_o,
    output logic [PLEN_W-1:0] pcnt_o,
    output logic              irq_o
);
    logic [NCAT-1:0]   stat_q;
    logic [PLEN_W-1:0] pcnt_q;
    logic              trig;

    assign trig   = |(set_i & en);
    assign stat_o = stat_q;
    assign pcnt_o = pcnt_q;
    assign irq_o  = pulse_mode ? (pcnt_q != '0) : |(stat_q & en);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            pcnt_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_i) | set_i;
            if (trig)               pcnt_q <= plen;
            else if (pcnt_q != '0)  pcnt_q <= pcnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
    import irq_aggr_pkg::*;
#(
    parameter int NDESC    = 32,
    parameter int PLEN_W   = 8,
    parameter int PLEN_RST = 8,
    parameter int IVAL_W   = 16,
    parameter int IVAL_RST = 100
) (
    input  logic             clk_aon,
    input  logic             rst,
    input  logic [NDESC-1:0] iso_evt_i,
    input  logic [NDESC-1:0] intr_evt_i,
    input  logic [NDESC-1:0] bulk_evt_i,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [NDESC-1:0] reg_wdata,
    output logic [NDESC-1:0] reg_rdata,
    output logic             irq_o
);
    logic [NDESC-1:0]  evt    [NCAT];
    logic [NDESC-1:0]  done_m [NCAT];
    logic [NDESC-1:0]  all_m  [NCAT];
    logic [NDESC-1:0]  any_m  [NCAT];
    logic [NCAT-1:0]   req, set, stat_q, stat_clr;
    logic [NCAT-1:0]   en_q;
    ctrl_t             ctrl_q;
    logic [PLEN_W-1:0] plen_q, pcnt;
    logic [IVAL_W-1:0] ival_q;
    logic              bulk_expire;

    assign evt[CAT_ISO]  = iso_evt_i;
    assign evt[CAT_INTR] = intr_evt_i;
    assign evt[CAT_BULK] = bulk_evt_i;

    genvar c;
    generate
        for (c = 0; c < NCAT; c++) begin : g_cat
            irq_cat_eval #(.NDESC(NDESC)) u_cat (
                .clk     (clk_aon),
                .rst     (rst),
                .evt_i   (evt[c]),
                .done_we (reg_we && reg_addr == cat_addr(A_DONE_BASE, c)),
                .all_we  (reg_we && reg_addr == cat_addr(A_ALL_BASE, c)),
                .any_we  (reg_we && reg_addr == cat_addr(A_ANY_BASE, c)),
                .wdata   (reg_wdata),
                .done_o  (done_m[c]),
                .all_o   (all_m[c]),
                .any_o   (any_m[c]),
                .req_o   (req[c])
            );
        end
    endgenerate

    assign set[CAT_ISO]  = req[CAT_ISO];
    assign set[CAT_INTR] = req[CAT_INTR];

    irq_bulk_throttle #(.IVAL_W(IVAL_W)) u_thr (
        .clk      (clk_aon),
        .rst      (rst),
        .ival_en  (ctrl_q.ival_en),
        .ival_len (ival_q),
        .req_i    (req[CAT_BULK]),
        .set_o    (set[CAT_BULK]),
        .expire_o (bulk_expire)
    );

    assign stat_clr = (reg_we && reg_addr == A_STAT) ? reg_wdata[NCAT-1:0] : '0;

    irq_line_gen #(.NCAT(NCAT), .PLEN_W(PLEN_W)) u_line (
        .clk        (clk_aon),
        .rst        (rst),
        .pulse_mode (ctrl_q.pulse_mode),
        .en         (en_q),
        .set_i      (set),
        .clr_i      (stat_clr),
        .plen       (plen_q),
        .stat_o     (stat_q),
        .pcnt_o     (pcnt),
        .irq_o      (irq_o)
    );

    always_ff @(posedge clk_aon) begin
        if (rst) begin
            en_q   <= '0;
            ctrl_q <= '0;
            plen_q <= PLEN_W'(PLEN_RST);
            ival_q <= IVAL_W'(IVAL_RST);
        end else if (reg_we) begin
            case (reg_addr)
                A_EN:    en_q   <= reg_wdata[NCAT-1:0];
                A_CTRL:  ctrl_q <= reg_wdata[1:0];
                A_PLEN:  plen_q <= reg_wdata[PLEN_W-1:0];
                A_IVAL:  ival_q <= reg_wdata[IVAL_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int k = 0; k < NCAT; k++) begin
            if (reg_addr == cat_addr(A_DONE_BASE, k)) reg_rdata = done_m[k];
            if (reg_addr == cat_addr(A_ALL_BASE, k))  reg_rdata = all_m[k];
            if (reg_addr == cat_addr(A_ANY_BASE, k))  reg_rdata = any_m[k];
        end
        case (reg_addr)
            A_STAT:  reg_rdata = NDESC'(stat_q);
            A_EN:    reg_rdata = NDESC'(en_q);
            A_CTRL:  reg_rdata = NDESC'(ctrl_q);
            A_PLEN:  reg_rdata = NDESC'(plen_q);
            A_IVAL:  reg_rdata = NDESC'(ival_q);
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk
    import irq_aggr_pkg::*;
#(
    parameter int NDESC  = 32,
    parameter int PLEN_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [NDESC-1:0]  iso_evt,
    input logic [NDESC-1:0]  iso_any,
    input logic              reg_we,
    input logic [3:0]        reg_addr,
    input logic [NDESC-1:0]  reg_wdata,
    input logic [2:0]        stat,
    input logic [1:0]        ctrl,
    input logic              expire,
    input logic [PLEN_W-1:0] pcnt,
    input logic              irq
);
    logic [2:0] keep;
    assign keep = stat & ~((reg_we && reg_addr == A_STAT) ? reg_wdata[2:0] : 3'b000);

    assert_any_fast_R1: assert property (@(posedge clk) disable iff (rst)
        (|(iso_evt & iso_any)) |-> ##2 stat[0]);

    assert_status_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat & $past(keep)) == $past(keep)));

    assert_level_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (!ctrl[0] && irq && !reg_we) |=> irq);

    assert_pulse_length_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl[0] && pcnt > 1 && !reg_we) |=> irq);

    assert_bulk_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (ctrl[1] && !expire && !stat[2]) |=> !stat[2]);
endmodule

bind irq_aggr_top irq_aggr_chk #(.NDESC(NDESC), .PLEN_W(PLEN_W)) u_chk (
    .clk       (clk_aon),
    .rst       (rst),
    .iso_evt   (iso_evt_i),
    .iso_any   (any_m[0]),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .stat      (stat_q),
    .ctrl      (ctrl_q),
    .expire    (bulk_expire),
    .pcnt      (pcnt),
    .irq       (irq_o)
);

// File: tb/irq_aggr_top_tb.sv
module irq_aggr_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] iso_evt = '0, intr_evt = '0, bulk_evt = '0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_o;

    int n_run = 0, n_fail = 0;
    bit started = 0, finished = 0;

    always #2 clk = ~clk;

    irq_aggr_top u_dut (
        .clk_aon(clk), .rst(rst), .iso_evt_i(iso_evt), .intr_evt_i(intr_evt),
        .bulk_evt_i(bulk_evt), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    // Behavioural reference model
    logic [31:0] m_done[3], m_all[3], m_any[3];
    bit          m_anyhit[3], m_allseen[3];
    logic [2:0]  m_stat, m_en;
    logic [1:0]  m_ctrl;
    logic [7:0]  m_plen, m_pcnt;
    logic [15:0] m_ival, m_tmr;
    bit          m_hold;

    function automatic logic [31:0] evt_of(int c);
        return (c == 0) ? iso_evt : (c == 1) ? intr_evt : bulk_evt;
    endfunction

    function automatic logic [31:0] m_read(logic [3:0] a);
        if (a <= 2) return m_done[a];
        if (a <= 5) return m_all[a-3];
        if (a <= 8) return m_any[a-6];
        case (a)
            9:  return {29'd0, m_stat};
            10: return {29'd0, m_en};
            11: return {30'd0, m_ctrl};
            12: return {24'd0, m_plen};
            13: return {16'd0, m_ival};
            default: return 32'd0;
        endcase
    endfunction

    function automatic bit m_irq();
        return m_ctrl[0] ? (m_pcnt != 0) : ((m_stat & m_en) != 0);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < 3; c++) begin
                m_done[c] = 0; m_all[c] = 0; m_any[c] = 0;
                m_anyhit[c] = 0; m_allseen[c] = 0;
            end
            m_stat = 0; m_en = 0; m_ctrl = 0; m_plen = 8; m_pcnt = 0;
            m_ival = 100; m_tmr = 0; m_hold = 0;
        end else begin
            bit met[3];
            bit req[3];
            bit expire, bset;
            logic [2:0] setv, clr;
            for (int c = 0; c < 3; c++) begin
                met[c] = (m_all[c] != 0) && ((m_done[c] & m_all[c]) == m_all[c]);
                req[c] = m_anyhit[c] || (met[c] && !m_allseen[c]);
            end
            expire = m_ctrl[1] && (m_tmr == 0);
            bset   = m_ctrl[1] ? (expire && (m_hold || req[2])) : req[2];
            setv   = {bset, req[1], req[0]};
            clr    = (reg_we && reg_addr == 9) ? reg_wdata[2:0] : 3'b0;
            m_hold = (!m_ctrl[1] || expire) ? 1'b0 : (m_hold || req[2]);
            m_tmr  = (!m_ctrl[1] || expire) ? m_ival - 16'd1 : m_tmr - 16'd1;
            if ((setv & m_en) != 0) m_pcnt = m_plen;
            else if (m_pcnt != 0)   m_pcnt = m_pcnt - 8'd1;
            m_stat = (m_stat & ~clr) | setv;
            for (int c = 0; c < 3; c++) begin
                m_anyhit[c]  = (evt_of(c) & m_any[c]) != 0;
                m_allseen[c] = met[c];
                m_done[c]    = (m_done[c] & ~((reg_we && reg_addr == 4'(c)) ? reg_wdata : 32'd0)) | evt_of(c);
            end
            if (reg_we) begin
                if (reg_addr >= 3 && reg_addr <= 5) m_all[reg_addr-3] = reg_wdata;
                if (reg_addr >= 6 && reg_addr <= 8) m_any[reg_addr-6] = reg_wdata;
                if (reg_addr == 10) m_en   = reg_wdata[2:0];
                if (reg_addr == 11) m_ctrl = reg_wdata[1:0];
                if (reg_addr == 12) m_plen = reg_wdata[7:0];
                if (reg_addr == 13) m_ival = reg_wdata[15:0];
            end
        end
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the edge
    always @(negedge clk) begin
        #1;
        if (started && !rst && !finished) begin
            chk(m_ctrl[0] ? "R7 line vs model" : "R6 line vs model", 32'(irq_o), 32'(m_irq()));
            chk("R12 read vs model", reg_rdata, m_read(reg_addr));
        end
    end

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 0; reg_wdata = 0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic pulse(int c, logic [31:0] bits);
        @(negedge clk);
        if (c == 0) iso_evt = bits; else if (c == 1) intr_evt = bits; else bulk_evt = bits;
        @(negedge clk);
        iso_evt = 0; intr_evt = 0; bulk_evt = 0;
    endtask

    initial begin
        logic [31:0] v;
        int hi;
        rst = 1; idle(3); rst = 0; started = 1;
        // R12 reset state
        rd(12, v); chk("R12 pulse length reset", v, 8);
        rd(13, v); chk("R12 interval reset", v, 100);
        rd(9, v);  chk("R12 status reset", v, 0);
        chk("R12 line reset", 32'(irq_o), 0);

        // R1 any-mask, R5 enable, R6 level
        wr(10, 0); wr(6, 32'h80);
        pulse(0, 32'h80); idle(1);
        rd(9, v); chk("R5 status set without enable", v, 1);
        chk("R5 line low without enable", 32'(irq_o), 0);
        wr(9, 1); wr(10, 7);
        pulse(0, 32'h80); idle(1);
        rd(9, v); chk("R1 any-mask request", v, 1);
        chk("R6 line high in level mode", 32'(irq_o), 1);
        idle(4); chk("R6 line holds", 32'(irq_o), 1);
        wr(9, 0); chk("R5 write 0 keeps status", 32'(irq_o), 1);
        wr(9, 1); chk("R6 line drops after clear", 32'(irq_o), 0);
        rd(0, v); chk("R4 done map persists", v, 32'h80);
        wr(0, 32'h80); rd(0, v); chk("R4 done cleared by w1c", v, 0);

        // R2 all-mask, R11 re-arm, R3 isolation
        wr(4, 32'h414);
        pulse(1, 32'h4); pulse(1, 32'h10); idle(2);
        rd(9, v); chk("R2 partial all-mask silent", v, 0);
        pulse(1, 32'h400); idle(1);
        rd(9, v); chk("R2 all-mask met", v, 2);
        wr(9, 2);
        pulse(1, 32'h4); idle(2);
        rd(9, v); chk("R11 re-set bit does not refire", v, 0);
        wr(1, 32'h10); pulse(1, 32'h10); idle(1);
        rd(9, v); chk("R11 re-armed after clear", v, 2);
        wr(9, 7);
        wr(3, 32'h8); pulse(1, 32'h8); idle(2);
        rd(9, v); chk("R3 no cross-category request", v, 0);
        wr(3, 0); wr(1, 32'hFFFF_FFFF); wr(4, 0); wr(6, 0);

        // R7 pulse mode with clear during pulse
        wr(6, 32'h1); wr(12, 5); wr(11, 1);
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            iso_evt = (i == 0) ? 32'h1 : 32'h0;
            reg_we = (i == 3); reg_addr = 9; reg_wdata = (i == 3) ? 32'h7 : 32'h0;
            #1; if (irq_o) hi++;
        end
        reg_we = 0;
        chk("R7 pulse length fixed despite clear", hi, 5);
        // R8 restart
        hi = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            iso_evt = (i == 0 || i == 2) ? 32'h1 : 32'h0;
            #1; if (irq_o) hi++;
        end
        chk("R8 pulse restarts", hi, 7);
        wr(11, 0); wr(9, 7); wr(0, 32'hFFFF_FFFF); wr(6, 0);

        // R9 bulk interval, R10 empty expiry
        wr(8, 32'h1); wr(13, 20); idle(2); wr(11, 2);
        pulse(2, 32'h1); idle(4);
        rd(9, v); chk("R9 bulk held before expiry", v, 0);
        idle(16);
        rd(9, v); chk("R9 bulk released at expiry", v, 4);
        wr(9, 4); idle(45);
        rd(9, v); chk("R10 empty expiry raises nothing", v, 0);
        wr(11, 0); wr(9, 7);

        // Random traffic, compared against the model every cycle
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            iso_evt  = $urandom & $urandom & $urandom & $urandom;
            intr_evt = $urandom & $urandom & $urandom & $urandom;
            bulk_evt = $urandom & $urandom & $urandom & $urandom;
            reg_addr = 4'($urandom_range(0, 15));
            reg_we   = ($urandom_range(0, 7) == 0);
            reg_wdata = $urandom;
            if (reg_addr == 12) reg_wdata = 32'($urandom_range(1, 10));
            if (reg_addr == 13) reg_wdata = 32'($urandom_range(1, 40));
        end
        @(negedge clk); reg_we = 0; iso_evt = 0; intr_evt = 0; bulk_evt = 0;
        idle(2);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            finished = 1;
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule